// File: doc/BRIEF.md
# Multiplexed External Data Bus Sequencer

This block runs one external data-memory transfer at a time on a multiplexed 8-bit bus. A core presents a read or write request with a 16-bit data pointer, an 8-bit register-indirect pointer, a flag that selects which pointer supplies the low address byte, and a write byte. The sequencer then steps through a fixed timeline that is counted in oscillator clock periods, with one `clk` period per oscillator period. First it places the low address byte on the shared port while the latch strobe is high. It keeps that byte there briefly after the strobe falls. It then either drives the write byte or releases the port. Next it pulses the read or write strobe, and finally it waits one gap period before another transfer may begin.

The upper address byte always comes from the high byte of the data pointer. It is driven on its own port for the whole transfer. Read data is captured from the shared port on the last clock edge of the read pulse and is returned together with a one-period done pulse. The program-store enable output stays inactive at all times.

Top module: `xbus_seq`

## Requirements
- R1: A synchronous active-high reset puts the block idle with `ale` low, `rd_n` and `wr_n` high, `ad_oe` low, `done` low and `ready` high.
- R2: A request is taken on a clock edge where `req_valid` and `ready` are both high. For the next 2 periods `ale` is high and `ad_out` (with `ad_oe` high) carries the low address byte. That byte is `req_rptr` when `req_indirect` is 1 and `req_dptr[7:0]` when it is 0.
- R3: After `ale` falls, the low address byte stays on `ad_out` with `ad_oe` high for 2 more periods.
- R4: During every period of a transfer, `a_hi` equals `req_dptr[15:8]` of the accepted request.
- R5: The strobe falls 3 periods after `ale` falls and stays low for exactly 6 periods. Only `wr_n` (when `req_write` is 1) or only `rd_n` (when `req_write` is 0) pulses, and `ale` is low while either strobe is low.
- R6: For a write, `ad_out` carries the write byte with `ad_oe` high from 1 period before `wr_n` falls through the 1 period after `wr_n` rises.
- R7: For a read, `ad_oe` goes low 1 period before `rd_n` falls and stays low until the transfer ends. The value on `ad_in` in the last period of the read pulse appears on `rdata` during the done period.
- R8: `done` is high for exactly the 1 period right after the strobe rises. `ready` is high while idle and during that period, and low for the rest of a transfer. A request made while `ready` is low is ignored.
- R9: A request taken during the done period makes `ale` rise in the very next period, 1 period after the previous strobe rose.
- R10: `psen_n` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = low address from `req_rptr` |
| req_dptr | input | 16 | Data pointer |
| req_rptr | input | 8 | Register-indirect pointer |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Request can be taken this period |
| done | output | 1 | Transfer finished, `rdata` valid |
| rdata | output | 8 | Captured read byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| psen_n | output | 1 | Program-store enable, held inactive |
| ad_out | output | 8 | Shared address/data port output value |
| ad_oe | output | 1 | Drive enable for the shared port |
| ad_in | input | 8 | Shared port input value |
| a_hi | output | 8 | Upper address byte |

## Verification
Transfers cover every pairing of direction and low-address source, so a swapped pointer select or a pulse on the wrong strobe shows up at once. The bench drives a decoy value on `ad_in` in every period except the last one of the read pulse, which separates a correct capture from one taken a period too early or too late. A second request that waits on `ready` checks the one-period gap between transfers. Requests raised in the middle of a transfer with different fields must leave every output unchanged.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_HOLD,
        PH_SETUP,
        PH_STROBE,
        PH_GAP
    } phase_e;
endpackage

// File: rtl/xbus_addr_sel.sv
module xbus_addr_sel #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              indirect,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [DATA_W-1:0] rptr,
    output logic [DATA_W-1:0] lo,
    output logic [HI_W-1:0]   hi
);
    always_comb begin
        lo = indirect ? rptr : dptr[DATA_W-1:0];
        hi = dptr[ADDR_W-1:DATA_W];
    end
endmodule

// File: rtl/xbus_phase.sv
module xbus_phase
    import xbus_pkg::*;
#(
    parameter int ALE_CYC    = 2,
    parameter int ALE_TO_STB = 3,
    parameter int STB_CYC    = 6,
    localparam int HOLD_CYC  = ALE_TO_STB - 1,
    localparam int CNT_W     = $clog2(ALE_CYC + HOLD_CYC + STB_CYC + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   last,
    output logic   ready
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        unique case (s_q.ph)
            PH_ADDR:   last = (s_q.cnt == CNT_W'(ALE_CYC - 1));
            PH_HOLD:   last = (s_q.cnt == CNT_W'(HOLD_CYC - 1));
            PH_SETUP:  last = 1'b1;
            PH_STROBE: last = (s_q.cnt == CNT_W'(STB_CYC - 1));
            default:   last = 1'b0;
        endcase
        ready = (s_q.ph == PH_IDLE) || (s_q.ph == PH_GAP);
        phase = s_q.ph;
    end

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
        unique case (s_q.ph)
            PH_IDLE, PH_GAP: begin
                s_d.cnt = '0;
                s_d.ph  = start ? PH_ADDR : PH_IDLE;
            end
            PH_ADDR: if (last) begin
                s_d.ph  = PH_HOLD;
                s_d.cnt = '0;
            end
            PH_HOLD: if (last) begin
                s_d.ph  = PH_SETUP;
                s_d.cnt = '0;
            end
            PH_SETUP: begin
                s_d.ph  = PH_STROBE;
                s_d.cnt = '0;
            end
            PH_STROBE: if (last) begin
                s_d.ph  = PH_GAP;
                s_d.cnt = '0;
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.ph  <= PH_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int ALE_CYC    = 2,
    parameter int ALE_TO_STB = 3,
    parameter int STB_CYC    = 6,
    localparam int HI_W      = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_indirect,
    input  logic [ADDR_W-1:0] req_dptr,
    input  logic [DATA_W-1:0] req_rptr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              psen_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   a_hi
);
    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] lo;
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
    } xfer_t;

    xfer_t  x_q, x_d;
    phase_e phase;
    logic   last;
    logic   start;
    logic [DATA_W-1:0] sel_lo;
    logic [HI_W-1:0]   sel_hi;

    assign start = req_valid && ready;

    xbus_addr_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
        .indirect (req_indirect),
        .dptr     (req_dptr),
        .rptr     (req_rptr),
        .lo       (sel_lo),
        .hi       (sel_hi)
    );

    xbus_phase #(.ALE_CYC(ALE_CYC), .ALE_TO_STB(ALE_TO_STB), .STB_CYC(STB_CYC)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .last  (last),
        .ready (ready)
    );

    always_comb begin
        x_d = x_q;
        if (start) begin
            x_d.wr = req_write;
            x_d.lo = sel_lo;
            x_d.hi = sel_hi;
            x_d.wd = req_wdata;
        end
        if (phase == PH_STROBE && last && !x_q.wr) begin
            x_d.rd = ad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

    always_comb begin
        ale    = (phase == PH_ADDR);
        rd_n   = !(phase == PH_STROBE && !x_q.wr);
        wr_n   = !(phase == PH_STROBE && x_q.wr);
        psen_n = 1'b1;
        ad_oe  = (phase == PH_ADDR) || (phase == PH_HOLD) ||
                 (x_q.wr && (phase == PH_SETUP || phase == PH_STROBE || phase == PH_GAP));
        ad_out = (phase == PH_ADDR || phase == PH_HOLD) ? x_q.lo : x_q.wd;
        a_hi   = x_q.hi;
        done   = (phase == PH_GAP);
        rdata  = x_q.rd;
    end
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ale,
    input logic              rd_n,
    input logic              wr_n,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic [HI_W-1:0]   a_hi,
    input logic              done
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R5
    AST_STROBE_NO_ALE: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !ale); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (ad_oe && $stable(ad_out))); // R3
    AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
        ((!rd_n || !wr_n) && $past(!rd_n || !wr_n)) |-> $stable(a_hi)); // R4
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe); // R6
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(!rd_n || !wr_n) && rd_n && wr_n)); // R8
endmodule

bind xbus_seq xbus_seq_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .ad_oe  (ad_oe),
    .ad_out (ad_out),
    .a_hi   (a_hi),
    .done   (done)
);

// File: tb/xbus_seq_test.sv
module xbus_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_indirect = 1'b0;
    logic [15:0] req_dptr = '0;
    logic [7:0]  req_rptr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  ad_in = '0;
    logic        ready, done, ale, rd_n, wr_n, psen_n, ad_oe;
    logic [7:0]  rdata, ad_out, a_hi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference timeline: period 1..12 of a transfer
    bit       m_busy = 1'b0;
    int       m_t = 0;
    bit       m_wr, m_b2b;
    logic [7:0] m_lo, m_hi, m_wd, m_rb, m_exp_rd;
    logic [7:0] rb_next = 8'h00;

    always #10 clk = ~clk;

    xbus_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_indirect(req_indirect), .req_dptr(req_dptr), .req_rptr(req_rptr),
        .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 1'b0;
            m_t    = 0;
            m_exp_rd = 8'h00;
        end else begin
            if (m_busy && m_t == 11 && !m_wr) m_exp_rd = ad_in;
            if ((!m_busy || m_t == 12) && req_valid) begin
                m_b2b  = m_busy;
                m_busy = 1'b1;
                m_t    = 1;
                m_wr   = req_write;
                m_lo   = req_indirect ? req_rptr : req_dptr[7:0];
                m_hi   = req_dptr[15:8];
                m_wd   = req_wdata;
                m_rb   = rb_next;
            end else if (m_busy) begin
                if (m_t == 12) begin
                    m_busy = 1'b0;
                    m_t    = 0;
                end else begin
                    m_t++;
                end
            end
        end
    end

    // read bus: correct byte only in the last period of the read pulse
    always @(negedge clk) begin
        ad_in = (m_busy && m_t == 11) ? m_rb : ~m_rb;
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit e_ale, e_rd, e_wr, e_oe, e_done, e_rdy;
            e_ale  = m_busy && m_t <= 2;
            e_rd   = !(m_busy && !m_wr && m_t >= 6 && m_t <= 11);
            e_wr   = !(m_busy && m_wr && m_t >= 6 && m_t <= 11);
            e_oe   = m_busy && (m_t <= 4 || m_wr);
            e_done = m_busy && m_t == 12;
            e_rdy  = !m_busy || m_t == 12;
            chk(ale == e_ale, (m_b2b && m_t == 1) ? "R9" : "R2", "ale", ale, e_ale);
            chk(rd_n == e_rd, "R5", "rd_n", rd_n, e_rd);
            chk(wr_n == e_wr, "R5", "wr_n", wr_n, e_wr);
            chk(ad_oe == e_oe, (m_t <= 2) ? "R2" : (m_t <= 4) ? "R3" : m_wr ? "R6" : "R7",
                "ad_oe", ad_oe, e_oe);
            if (e_oe) begin
                if (m_t <= 4) chk(ad_out == m_lo, (m_t <= 2) ? "R2" : "R3", "ad_out addr", ad_out, m_lo);
                else          chk(ad_out == m_wd, "R6", "ad_out data", ad_out, m_wd);
            end
            if (m_busy) chk(a_hi == m_hi, "R4", "a_hi", a_hi, m_hi);
            chk(done == e_done, "R8", "done", done, e_done);
            chk(ready == e_rdy, "R8", "ready", ready, e_rdy);
            chk(psen_n == 1'b1, "R10", "psen_n", psen_n, 1);
            if (e_done && !m_wr) chk(rdata == m_exp_rd, "R7", "rdata", rdata, m_exp_rd);
        end
    end

    task automatic issue(input bit wr, input bit ind, input logic [15:0] dp,
                         input logic [7:0] rp, input logic [7:0] wd, input logic [7:0] rb);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid    = 1'b1;
        req_write    = wr;
        req_indirect = ind;
        req_dptr     = dp;
        req_rptr     = rp;
        req_wdata    = wd;
        rb_next      = rb;
        @(negedge clk);
        req_valid    = 1'b0;
    endtask

    // R8: requests with other fields while busy must be ignored
    task automatic junk_during(input int n);
        for (int i = 0; i < n; i++) begin
            req_valid    = 1'b1;
            req_write    = ~req_write;
            req_indirect = ~req_indirect;
            req_dptr     = req_dptr ^ 16'hFFFF;
            req_rptr     = req_rptr + 8'h11;
            req_wdata    = req_wdata + 8'h22;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(ready && !done)) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ale == 1'b0, "R1", "ale", ale, 0);
        chk(rd_n == 1'b1, "R1", "rd_n", rd_n, 1);
        chk(wr_n == 1'b1, "R1", "wr_n", wr_n, 1);
        chk(ad_oe == 1'b0, "R1", "ad_oe", ad_oe, 0);
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(ready == 1'b1, "R1", "ready", ready, 1);
        rst = 1'b0;
        @(negedge clk);

        issue(1'b1, 1'b0, 16'h12A5, 8'h00, 8'h3C, 8'h00); wait_idle();
        issue(1'b0, 1'b0, 16'h8001, 8'h00, 8'h00, 8'h5A); wait_idle();
        issue(1'b1, 1'b1, 16'hBE00, 8'h77, 8'hC3, 8'h00); wait_idle();
        issue(1'b0, 1'b1, 16'h4F10, 8'h9D, 8'h00, 8'hA6); wait_idle();
        // R9: back-to-back, second request taken in the done period
        issue(1'b1, 1'b0, 16'h0102, 8'h00, 8'h81, 8'h00);
        issue(1'b0, 1'b1, 16'hFE03, 8'h44, 8'h00, 8'h18);
        issue(1'b1, 1'b1, 16'h7766, 8'hF0, 8'h0F, 8'h00); wait_idle();
        // R8: ignored requests mid-transfer
        issue(1'b0, 1'b0, 16'hC0DE, 8'h00, 8'h00, 8'hB2);
        junk_during(7);
        wait_idle();
        issue(1'b1, 1'b1, 16'h55AA, 8'h33, 8'h99, 8'h00);
        junk_during(8);
        wait_idle();
        // reset mid-transfer returns to R1 state
        issue(1'b1, 1'b0, 16'h2222, 8'h00, 8'h11, 8'h00);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(ad_oe == 1'b0, "R1", "ad_oe after reset", ad_oe, 0);
        chk(wr_n == 1'b1, "R1", "wr_n after reset", wr_n, 1);
        chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule